// File: doc/BRIEF.md
# UTOPIA Multi-PHY Transmit Master Scheduler

This block sits on the ATM-layer side of a shared transmit cell bus that serves several PHY devices. It drives the bus address, the active-low enable, the start-of-cell strobe and the 16-bit data. It also samples the single cell-available line that the PHY devices share. While the address bus is not needed for selection, the block keeps polling. It walks through a configured list of PHY addresses and puts the null address 1Fh on the bus between any two of them. For each poll it records whether the polled device reported room for a cell.

When the cell source presents a word and at least one enabled device has reported room, the block picks a device in round-robin order. It puts that device's address on the bus with enable high for one cycle, which is the selection cycle. It then pulls enable low and streams the 27 words of the cell, with start-of-cell marking the first word. Polling of the address list goes on while the cell is being written.

If the source stalls in the middle of a cell, the block raises enable and re-selects the same device before it resumes. If the device just served is the only one with room and another cell is ready, that cell follows with no gap.

Top module: `utx_mphy_master`

## Requirements
- R1: While reset is held, bus_addr is 1Fh, bus_enb is 1, bus_soc is 0, bus_data is 0 and src_ready is 0.
- R2: A cycle that shows a polled device address is followed by a cycle showing the null address 1Fh, unless a selection cycle takes that slot. Two polled addresses never appear back to back, and while nothing is being selected the null address never appears twice in a row.
- R3: Polled addresses follow the list order: entry 0 first after reset, then ascending index with wrap-around, counting only entries whose phy_en bit is 1. Entry i of phy_addr_list occupies bits [5i+4:5i].
- R4: An entry whose phy_en bit is 0 is never polled and never selected, even if its device would report room.
- R5: Every change of bus_enb from 1 to 0 is preceded by a cycle in which bus_enb is 1 and bus_addr holds the address of the device that receives the words. The only exception is a back-to-back cell (R10).
- R6: bus_soc is 1 only in a cycle where bus_enb is 0 and bus_data carries word 0 of a cell.
- R7: A cell is 27 words, carried in cycles where bus_enb is 0, in the order the source offered them. A word is accepted on a rising edge where src_valid and src_ready are both 1.
- R8: In the cycle after word 26, bus_enb is 1 unless a back-to-back cell follows.
- R9: Polling continues during a cell write, so non-null addresses appear on bus_addr in cycles where bus_enb is 0.
- R10: If the device just served is the only enabled device whose recorded status shows room, and the source already offers the next cell, word 0 of that cell follows word 26 in the very next cycle with bus_enb still 0.
- R11: The device chosen is the first enabled device with recorded room, searching in index order from the entry after the one last selected. After reset, the search starts at entry 0.
- R12: If src_valid drops in the middle of a cell, bus_enb goes to 1. The cycle before the write resumes shows the same device's address. The resumed word carries no start-of-cell.
- R13: A device's cell-available response is taken from the cycle after the cycle in which its address was shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr_list | input | NUM_PHY*5 | Bus address of each PHY entry, entry i in bits [5i+4:5i] |
| phy_en | input | NUM_PHY | 1 marks an entry as active |
| src_valid | input | 1 | Cell source offers a word |
| src_data | input | 16 | Offered word |
| src_ready | output | 1 | Word is taken at this edge when src_valid is also 1 |
| bus_addr | output | 5 | Bus address (poll, null or selection) |
| bus_enb | output | 1 | Active-low write enable |
| bus_soc | output | 1 | Start-of-cell, high with word 0 |
| bus_data | output | 16 | Cell word on the bus |
| bus_clav | input | 1 | Shared cell-available response |

## Verification
The bench models PHY devices that answer one cycle after their address appears. It uses several patterns of room reports:
- Room reported by a disabled entry only. This shows that disabled entries are skipped, not merely deprioritised.
- A single device that runs out of room after one cell. This isolates the selection handshake, the word order and the return of enable.
- A single device that keeps its room. This separates a back-to-back cell from a fresh selection.
- Two devices that both keep room. This shows the round-robin order.

A source stall in the middle of a cell tells a correct re-selection apart from a silent resume.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
// Shared types of the multi-PHY transmit master.
package utx_pkg;
    // Write controller state, i.e. what the bus shows in the current cycle.
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,   // no write, enable high, polling
        WR_SEL  = 2'd1,   // target address shown with enable high
        WR_XFER = 2'd2    // a cell word shown with enable low
    } wr_state_e;
endpackage

// File: rtl/utx_rr.sv
`timescale 1ns/1ps
// Round-robin pick over a request vector.
// Searches from the entry after 'last' and wraps around. 'last' itself is
// checked at the end. Purely combinational. Assumes N >= 1.
module utx_rr #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] pick
);
    int j;

    // Find the first requesting entry after 'last'.
    always_comb begin
        any  = 1'b0;
        pick = last;
        j    = 0;
        for (int k = 1; k <= N; k++) begin
            j = (int'(last) + k) % N;
            if (!any && req[j]) begin
                any  = 1'b1;
                pick = IW'(j);
            end
        end
    end
endmodule

// File: rtl/utx_poll.sv
`timescale 1ns/1ps
// Poll sequencer and room table.
// Owns the bus address register. It alternates polled addresses (enabled
// list entries in index order) with the null address. A selection request
// (ovr) takes the next slot and freezes the sequence. The cell-available
// line is sampled one cycle after a polled address was shown. A clear of an
// entry wins over a sample arriving at the same edge and cancels a sample
// still in flight for that entry.
module utx_poll #(
    parameter int                N         = 4,
    parameter int                AW        = 5,
    parameter int                IW        = 2,
    parameter logic [AW-1:0]     NULL_ADDR = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*AW-1:0] addr_list,
    input  logic [N-1:0]    en,
    input  logic            ovr,
    input  logic [AW-1:0]   ovr_addr,
    input  logic            clr,
    input  logic [IW-1:0]   clr_idx,
    input  logic            clav,
    output logic [AW-1:0]   addr_q,
    output logic            is_poll_q,
    output logic [N-1:0]    space_q
);
    logic            null_slot_q;
    logic [IW-1:0]   pidx_q, disp_idx_q, pend_idx_q, nxt_idx;
    logic            pend_q, found;
    logic [AW-1:0]   cur_addr;

    assign cur_addr = addr_list[int'(pidx_q)*AW +: AW];

    // Next enabled list entry after the current poll index.
    always_comb begin
        nxt_idx = pidx_q;
        found   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            if (!found && en[(int'(pidx_q) + k) % N]) begin
                found   = 1'b1;
                nxt_idx = IW'((int'(pidx_q) + k) % N);
            end
        end
    end

    // Address slot sequencing and the pending-sample pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= NULL_ADDR;
            is_poll_q   <= 1'b0;
            null_slot_q <= 1'b0;
            pidx_q      <= '0;
            disp_idx_q  <= '0;
            pend_q      <= 1'b0;
            pend_idx_q  <= '0;
        end else begin
            pend_q     <= is_poll_q && !(clr && clr_idx == disp_idx_q);
            pend_idx_q <= disp_idx_q;
            if (ovr) begin
                addr_q    <= ovr_addr;
                is_poll_q <= 1'b0;
            end else if (null_slot_q) begin
                addr_q      <= NULL_ADDR;
                is_poll_q   <= 1'b0;
                null_slot_q <= 1'b0;
                pidx_q      <= nxt_idx;
            end else if (en[pidx_q]) begin
                addr_q      <= cur_addr;
                is_poll_q   <= 1'b1;
                disp_idx_q  <= pidx_q;
                null_slot_q <= 1'b1;
            end else begin
                addr_q    <= NULL_ADDR;
                is_poll_q <= 1'b0;
                pidx_q    <= nxt_idx;
            end
        end
    end

    // Room table: clear on selection, otherwise record the delayed response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (clr && clr_idx == IW'(i))
                    space_q[i] <= 1'b0;
                else if (pend_q && pend_idx_q == IW'(i))
                    space_q[i] <= clav && en[i];
            end
        end
    end
endmodule

// File: rtl/utx_wr.sv
`timescale 1ns/1ps
// Cell write controller.
// Decides, one cycle ahead, what the bus shows: idle, a selection cycle for
// a target device, or a cell word. It counts the words of a cell, re-selects
// after a source stall and chains a back-to-back cell to the same device
// when that device is the only one with room. Assumes 'space' is already
// masked by the enabled entries.
module utx_wr
    import utx_pkg::*;
#(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int WORDS = 27,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    input  logic [N-1:0]  space,
    output logic          ovr,
    output logic [IW-1:0] ovr_idx,
    output logic          clr,
    output logic [IW-1:0] clr_idx,
    output logic          enb_q,
    output logic          soc_q,
    output logic [DW-1:0] data_q
);
    localparam int CW = $clog2(WORDS + 1);

    wr_state_e      st_q, st_d;
    logic [IW-1:0]  tgt_q, tgt_d, last_q, last_d, pick;
    logic [CW-1:0]  wcnt_q, wcnt_d, wbase;
    logic           any, cell_done, b2b, accept, enb_d, soc_d;
    logic [DW-1:0]  data_d;

    utx_rr #(.N(N), .IW(IW)) u_rr (
        .req (space),
        .last(last_q),
        .any (any),
        .pick(pick)
    );

    assign cell_done = (wcnt_q == CW'(WORDS));
    assign b2b       = src_valid && cell_done && space[tgt_q] && any && (pick == tgt_q);
    assign src_ready = (st_q == WR_SEL) || ((st_q == WR_XFER) && (!cell_done || b2b));
    assign ovr       = (st_d == WR_SEL);
    assign ovr_idx   = tgt_d;

    // Next bus contents and controller state.
    always_comb begin
        st_d    = st_q;
        tgt_d   = tgt_q;
        last_d  = last_q;
        wcnt_d  = wcnt_q;
        wbase   = wcnt_q;
        enb_d   = 1'b1;
        soc_d   = 1'b0;
        data_d  = data_q;
        clr     = 1'b0;
        clr_idx = pick;
        accept  = 1'b0;
        case (st_q)
            WR_IDLE: begin
                if (src_valid && any) begin
                    st_d   = WR_SEL;
                    tgt_d  = pick;
                    last_d = pick;
                    clr    = 1'b1;
                    wcnt_d = '0;
                end
            end
            WR_SEL: begin
                if (src_valid) begin
                    st_d   = WR_XFER;
                    accept = 1'b1;
                end
            end
            WR_XFER: begin
                if (cell_done) begin
                    if (b2b) begin
                        accept  = 1'b1;
                        wbase   = '0;
                        clr     = 1'b1;
                        clr_idx = tgt_q;
                    end else if (src_valid && any) begin
                        st_d   = WR_SEL;
                        tgt_d  = pick;
                        last_d = pick;
                        clr    = 1'b1;
                        wcnt_d = '0;
                    end else begin
                        st_d = WR_IDLE;
                    end
                end else if (src_valid) begin
                    accept = 1'b1;
                end else begin
                    st_d = WR_SEL;
                end
            end
            default: st_d = WR_IDLE;
        endcase
        if (accept) begin
            enb_d  = 1'b0;
            soc_d  = (wbase == '0);
            data_d = src_data;
            wcnt_d = wbase + CW'(1);
        end
    end

    // State and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WR_IDLE;
            tgt_q  <= '0;
            last_q <= IW'(N - 1);
            wcnt_q <= '0;
            enb_q  <= 1'b1;
            soc_q  <= 1'b0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            tgt_q  <= tgt_d;
            last_q <= last_d;
            wcnt_q <= wcnt_d;
            enb_q  <= enb_d;
            soc_q  <= soc_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/utx_mphy_master.sv
`timescale 1ns/1ps
// Multi-PHY transmit master: top level.
// Combines the poll sequencer (address bus, room table) with the write
// controller (enable, start-of-cell, data). All bus outputs are registered
// and change on the same edge.
module utx_mphy_master #(
    parameter int                NUM_PHY    = 4,
    parameter int                ADDR_W     = 5,
    parameter int                DATA_W     = 16,
    parameter int                CELL_WORDS = 27,
    parameter logic [ADDR_W-1:0] NULL_ADDR  = 5'h1F
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PHY*ADDR_W-1:0] phy_addr_list,
    input  logic [NUM_PHY-1:0]        phy_en,
    input  logic                      src_valid,
    input  logic [DATA_W-1:0]         src_data,
    output logic                      src_ready,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      bus_enb,
    output logic                      bus_soc,
    output logic [DATA_W-1:0]         bus_data,
    input  logic                      bus_clav
);
    localparam int IW = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

    logic               sel_ovr, tbl_clr, poll_is_poll;
    logic [IW-1:0]      sel_idx, clr_idx;
    logic [ADDR_W-1:0]  sel_addr;
    logic [NUM_PHY-1:0] space_raw, space_req;

    assign sel_addr  = phy_addr_list[int'(sel_idx)*ADDR_W +: ADDR_W];
    assign space_req = space_raw & phy_en;

    utx_poll #(.N(NUM_PHY), .AW(ADDR_W), .IW(IW), .NULL_ADDR(NULL_ADDR)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_list(phy_addr_list),
        .en       (phy_en),
        .ovr      (sel_ovr),
        .ovr_addr (sel_addr),
        .clr      (tbl_clr),
        .clr_idx  (clr_idx),
        .clav     (bus_clav),
        .addr_q   (bus_addr),
        .is_poll_q(poll_is_poll),
        .space_q  (space_raw)
    );

    utx_wr #(.N(NUM_PHY), .IW(IW), .WORDS(CELL_WORDS), .DW(DATA_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_valid(src_valid),
        .src_data (src_data),
        .src_ready(src_ready),
        .space    (space_req),
        .ovr      (sel_ovr),
        .ovr_idx  (sel_idx),
        .clr      (tbl_clr),
        .clr_idx  (clr_idx),
        .enb_q    (bus_enb),
        .soc_q    (bus_soc),
        .data_q   (bus_data)
    );
endmodule

// File: rtl/utx_mphy_master_chk.sv
`timescale 1ns/1ps
// Bus protocol checker for utx_mphy_master, attached with bind.
// Tracks the number of enabled words since the last start-of-cell.
module utx_mphy_master_chk #(
    parameter int                ADDR_W     = 5,
    parameter int                CELL_WORDS = 27,
    parameter logic [ADDR_W-1:0] NULL_ADDR  = 5'h1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_enb,
    input logic              bus_soc,
    input logic              is_poll,
    input logic              sel_ovr
);
    localparam int CW = $clog2(CELL_WORDS + 1);
    logic [CW-1:0] cnt_q;

    // Count words shown on the bus since the last start-of-cell.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!bus_enb) cnt_q <= bus_soc ? CW'(1) : cnt_q + CW'(1);
    end

    // R2: a polled address is followed by the null address unless a selection takes the slot
    p_null_after_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_poll && !sel_ovr) |=> (bus_addr == NULL_ADDR));

    // R5: enable falls only after a non-null (selection) address
    p_sel_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_enb) |-> ($past(bus_addr) != NULL_ADDR));

    // R6: start-of-cell only with enable low
    p_soc_with_enb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_soc |-> !bus_enb);

    // R7: no cell runs past its last word
    p_cell_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_enb && !bus_soc) |-> (cnt_q < CW'(CELL_WORDS)));

    // R7: a new cell starts only at the beginning or after a full cell
    p_cell_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_enb && bus_soc) |-> (cnt_q == '0 || cnt_q == CW'(CELL_WORDS)));
endmodule

bind utx_mphy_master utx_mphy_master_chk #(
    .ADDR_W(ADDR_W), .CELL_WORDS(CELL_WORDS), .NULL_ADDR(NULL_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_enb (bus_enb),
    .bus_soc (bus_soc),
    .is_poll (poll_is_poll),
    .sel_ovr (sel_ovr)
);

// File: tb/utx_mphy_master_tb.sv
`timescale 1ns/1ps
// Directed bench: one task for each scenario, PHY devices modelled with a
// one-cycle cell-available response.
module utx_mphy_master_tb;
    localparam int NP = 4;
    localparam logic [4:0] NUL = 5'h1F;
    localparam logic [4:0] A0 = 5'h00, A1 = 5'h02, A2 = 5'h05, A3 = 5'h09;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [19:0] phy_addr_list;
    logic [3:0]  phy_en = 4'hF;
    logic        src_valid = 1'b0, src_ready, bus_enb, bus_soc, bus_clav = 1'b0;
    logic [15:0] src_data = '0, bus_data;
    logic [4:0]  bus_addr;

    assign phy_addr_list = {A3, A2, A1, A0};

    utx_mphy_master u_dut (
        .clk(clk), .rst_n(rst_n), .phy_addr_list(phy_addr_list), .phy_en(phy_en),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .bus_addr(bus_addr), .bus_enb(bus_enb), .bus_soc(bus_soc),
        .bus_data(bus_data), .bus_clav(bus_clav)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0, n_fail = 0;
    // source model state
    int src_cell, src_word, cells_goal, stall_word, stall_left;
    bit stall_done, acc_flag, drain;
    // PHY model
    bit [3:0] phy_space;
    logic [4:0] prev_addr;
    logic       prev_enb;
    // log
    logic [4:0]  lg_addr [256];
    logic        lg_enb  [256];
    logic        lg_soc  [256];
    logic [15:0] lg_data [256];
    int log_n;
    // analysis results
    int n_cells, hs_err, soc_err, data_err, poll_in_write;
    logic [4:0] cell_tgt [8];
    int  cell_first [8], cell_last [8], cell_len [8];
    bit  cell_b2b [8];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ent_addr(input int i);
        return phy_addr_list[i*5 +: 5];
    endfunction

    // One clock: advance the source, log the bus, answer polls.
    task automatic step();
        @(negedge clk);
        if (acc_flag) begin
            src_word++;
            if (src_word == 27) begin src_word = 0; src_cell++; end
        end
        if (stall_word >= 0 && !stall_done && src_cell == 0 && src_word == stall_word) begin
            stall_left = 3;
            stall_done = 1'b1;
        end
        src_valid = rst_n && (src_cell < cells_goal) && (stall_left == 0);
        if (stall_left > 0) stall_left--;
        src_data = {8'(src_cell), 8'(src_word)};
        #1;
        if (log_n < 256) begin
            lg_addr[log_n] = bus_addr; lg_enb[log_n] = bus_enb;
            lg_soc[log_n]  = bus_soc;  lg_data[log_n] = bus_data;
            log_n++;
        end
        if (drain && !bus_enb && bus_soc && prev_enb)
            for (int i = 0; i < NP; i++) if (ent_addr(i) == prev_addr) phy_space[i] = 1'b0;
        bus_clav = 1'b0;
        for (int i = 0; i < NP; i++)
            if (prev_addr == ent_addr(i) && phy_space[i]) bus_clav = 1'b1;
        prev_addr = bus_addr;
        prev_enb  = bus_enb;
        acc_flag  = src_valid && src_ready;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cells_goal = 0; src_cell = 0; src_word = 0; stall_word = -1;
        stall_left = 0; stall_done = 1'b0; acc_flag = 1'b0; drain = 1'b0;
        phy_space = '0; prev_addr = NUL; prev_enb = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        log_n = 0;
    endtask

    // Rebuild the cells seen on the bus from the log.
    task automatic analyze();
        int k, w;
        n_cells = 0; hs_err = 0; soc_err = 0; data_err = 0; poll_in_write = 0;
        k = -1; w = 0;
        for (int i = 1; i < log_n; i++) begin
            if (lg_soc[i] && lg_enb[i]) soc_err++;
            if (!lg_enb[i]) begin
                if (lg_enb[i-1] && lg_addr[i-1] == NUL) hs_err++;
                if (lg_soc[i]) begin
                    if (n_cells < 8) begin
                        k = n_cells; n_cells++;
                        cell_b2b[k] = !lg_enb[i-1];
                        cell_tgt[k] = lg_enb[i-1] ? lg_addr[i-1] : ((k > 0) ? cell_tgt[k-1] : NUL);
                        cell_first[k] = i; w = 0;
                    end
                end else if (k < 0) begin
                    soc_err++;
                end else if (lg_enb[i-1] && lg_addr[i-1] != cell_tgt[k]) begin
                    hs_err++;
                end
                if (lg_addr[i] != NUL) poll_in_write++;
                if (k >= 0) begin
                    if (lg_data[i] != {8'(k), 8'(w)}) data_err++;
                    w++; cell_len[k] = w; cell_last[k] = i;
                end
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk(bus_addr == NUL, "R1 addr", bus_addr, NUL);
        chk(bus_enb == 1'b1, "R1 enb", bus_enb, 1);
        chk(bus_soc == 1'b0, "R1 soc", bus_soc, 0);
        chk(bus_data == 16'h0, "R1 data", bus_data, 0);
        chk(src_ready == 1'b0, "R1 ready", src_ready, 0);
    endtask

    task automatic test_poll();
        int lows, seen_dis, bad_alt, dbl_null, bad_ord, pos;
        logic [4:0] ord [3];
        ord[0] = A0; ord[1] = A1; ord[2] = A3;
        do_reset();
        phy_en = 4'b1011; phy_space = 4'b0100; cells_goal = 1;
        repeat (40) step();
        lows = 0; seen_dis = 0; bad_alt = 0; dbl_null = 0; bad_ord = 0; pos = -1;
        for (int i = 0; i < log_n; i++) begin
            if (!lg_enb[i]) lows++;
            if (lg_addr[i] == A2) seen_dis++;
            if (i > 0 && lg_addr[i] != NUL && lg_addr[i-1] != NUL) bad_alt++;
            if (i > 0 && lg_addr[i] == NUL && lg_addr[i-1] == NUL) dbl_null++;
            if (lg_addr[i] != NUL) begin
                if (pos < 0) begin
                    pos = 0;
                    for (int m = 0; m < 3; m++) if (ord[m] == lg_addr[i]) pos = m;
                end else begin
                    pos = (pos + 1) % 3;
                    if (lg_addr[i] != ord[pos]) bad_ord++;
                end
            end
        end
        chk(lows == 0, "R4 no write to disabled entry", lows, 0);
        chk(seen_dis == 0, "R4 disabled entry not polled", seen_dis, 0);
        chk(bad_alt == 0, "R2 poll addresses separated by null", bad_alt, 0);
        chk(dbl_null == 0, "R2 no idle null pairs", dbl_null, 0);
        chk(bad_ord == 0 && pos >= 0, "R3 poll order", bad_ord, 0);
        chk(lg_addr[0] == A0, "R3 first poll after reset", lg_addr[0], A0);
        cells_goal = 0; phy_en = 4'hF;
    endtask

    task automatic test_cell();
        do_reset();
        phy_space = 4'b0010; drain = 1'b1; cells_goal = 1;
        repeat (80) step();
        analyze();
        chk(n_cells == 1, "R13 delayed response leads to one cell", n_cells, 1);
        chk(cell_tgt[0] == A1, "R5 target address in selection cycle", cell_tgt[0], A1);
        chk(hs_err == 0, "R5 selection handshake", hs_err, 0);
        chk(soc_err == 0 && lg_soc[cell_first[0]], "R6 start-of-cell with word 0", soc_err, 0);
        chk(data_err == 0, "R7 words in order", data_err, 0);
        chk(cell_len[0] == 27, "R7 cell length", cell_len[0], 27);
        chk(lg_enb[cell_last[0] + 1] == 1'b1, "R8 enable high after word 26", lg_enb[cell_last[0] + 1], 1);
        chk(poll_in_write > 0, "R9 polling during write", poll_in_write, 1);
    endtask

    task automatic test_b2b();
        do_reset();
        phy_space = 4'b0100; cells_goal = 2;
        repeat (120) step();
        analyze();
        chk(n_cells == 2, "R10 two cells", n_cells, 2);
        chk(cell_b2b[1] && cell_first[1] == cell_last[0] + 1, "R10 no gap between cells",
            cell_first[1] - cell_last[0], 1);
        chk(cell_tgt[0] == A2 && cell_tgt[1] == A2, "R10 same target", cell_tgt[1], A2);
        chk(data_err == 0 && cell_len[1] == 27, "R10 R7 second cell words", data_err, 0);
        chk(lg_enb[cell_last[1] + 1] == 1'b1, "R8 enable high after last cell", lg_enb[cell_last[1] + 1], 1);
    endtask

    task automatic test_rr();
        do_reset();
        phy_space = 4'b1001; cells_goal = 3;
        repeat (150) step();
        analyze();
        chk(n_cells == 3, "R11 three cells", n_cells, 3);
        chk(cell_tgt[0] == A0, "R11 first target", cell_tgt[0], A0);
        chk(cell_tgt[1] == A3, "R11 second target", cell_tgt[1], A3);
        chk(cell_tgt[2] == A0, "R11 third target", cell_tgt[2], A0);
        chk(!cell_b2b[1] && !cell_b2b[2] && hs_err == 0, "R11 R5 each cell reselected", hs_err, 0);
        chk(data_err == 0, "R11 R7 data", data_err, 0);
    endtask

    task automatic test_pause();
        int socs;
        do_reset();
        phy_space = 4'b0010; drain = 1'b1; cells_goal = 1; stall_word = 10;
        repeat (90) step();
        analyze();
        socs = 0;
        for (int i = 0; i < log_n; i++) if (lg_soc[i]) socs++;
        chk(n_cells == 1 && cell_len[0] == 27, "R12 one full cell", cell_len[0], 27);
        chk(data_err == 0, "R12 words continue in order", data_err, 0);
        chk(cell_last[0] - cell_first[0] + 1 > 27, "R12 enable rises during stall",
            cell_last[0] - cell_first[0] + 1, 28);
        chk(hs_err == 0, "R12 reselect same device", hs_err, 0);
        chk(socs == 1, "R12 no start-of-cell on resume", socs, 1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cells_goal = 0; src_cell = 0; src_word = 0; stall_word = -1; stall_left = 0;
        stall_done = 1'b0; acc_flag = 1'b0; drain = 1'b0; phy_space = '0;
        prev_addr = NUL; prev_enb = 1'b1; log_n = 0;
        test_reset();
        test_poll();
        test_cell();
        test_b2b();
        test_rr();
        test_pause();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule